// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital timing controller for a 10-bit successive-approximation converter. A module enable input arms it. A one-cycle start request then launches a sequence. The sequence can begin with an optional automatic acquisition delay, during which the sample/hold switch stays closed. It continues with an 11-period conversion window in which the trial code is refined one bit at a time from the MSB down. It ends with a 2-period discharge tail. All of these periods are counted in conversion-clock periods (TAD), one per pulse on the `tad_tick` input.

The trial code drives an external DAC and comparator. The comparator reports whether the analog input is at or above the trial value, and the block reads it at the end of each bit period. When the tail ends, the block does four things at a single clock edge: it loads the result register, drops busy, sets a sticky completion flag, and reconnects the sample/hold. If enable is removed at any point, the sequence is abandoned with no result and no flag.

Top module: `adc_sar_sequencer`

## Requirements
- R1: While `en` is 0, `go_set` is ignored and `busy` reads 0 on the cycle after any edge with `en` low.
- R2: A `go_set` pulse in the same cycle that `en` goes from 0 to 1 is ignored: `busy` stays 0.
- R3: An accepted start makes `busy` read 1 on the next cycle. That first busy cycle still has `sample_en` at 1 and ignores any `tad_tick` in it.
- R4: The acquisition delay is counted in `tad_tick` pulses while `busy` and `sample_en` are both 1. `acq_sel` selects the length, latched at the start: 000→0, 001→2, 010→4, 011→6, 100→8, 101→12, 110→16, 111→20.
- R5: `sample_en` is 0 from the start of conversion until completion. It is 1 at all other times.
- R6: Conversion lasts 11 TAD. The first TAD is setup. After the first conversion tick, `trial` is 10'h200 (bit 9 alone), and later bits are tried in descending order.
- R7: A tried bit is kept when `cmp_ge` is 1 at the end of its TAD and cleared otherwise. With an ideal comparator, `result` equals the input code.
- R8: A 2-TAD discharge follows the last bit, so 13 ticks in total are counted with `busy` 1 and `sample_en` 0.
- R9: On the edge after the discharge ends, `result` loads, `busy` falls, `irq_flag` rises and `sample_en` rises together. `result` is unchanged at every other time.
- R10: `irq_flag` stays set until an `irq_clr` pulse, which clears it on the next cycle.
- R11: Dropping `en` during a sequence returns the block to idle on the next edge. `busy` goes to 0, `sample_en` goes to 1, `result` is kept, and `irq_flag` is not set.
- R12: `go_set` while `busy` is 1 has no effect on timing or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Module enable |
| go_set | input | 1 | Start request pulse |
| acq_sel | input | 3 | Acquisition-length select |
| tad_tick | input | 1 | One pulse per conversion-clock period |
| cmp_ge | input | 1 | Comparator: input at or above trial |
| irq_clr | input | 1 | Clears the completion flag |
| busy | output | 1 | Sequence in progress |
| sample_en | output | 1 | Sample/hold switch closed |
| trial | output | 10 | Trial code to the DAC |
| result | output | 10 | Last completed conversion |
| irq_flag | output | 1 | Sticky completion flag |

## Verification
On every cycle, the assertions check several properties. Busy must fall after enable drops or an abort. The start cycle must still be sampling. Completion must follow a discharge tick. The MSB trial must appear after the setup tick. The result must move only at completion, together with the flag, and a clear must drop the flag. The bench's scenarios are what show the TAD counts per acquisition code, the 13-tick conversion-plus-discharge length, the converted value against an ideal comparator, and the refusal of a start in the same cycle as enable.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_ACQ,
    PH_CONV,
    PH_DISCH,
    PH_DONE
  } phase_e;

  // Acquisition length in TAD for each select code
  function automatic logic [4:0] acq_len(input logic [2:0] sel);
    logic [4:0] n;
    case (sel)
      3'd0:    n = 5'd0;
      3'd1:    n = 5'd2;
      3'd2:    n = 5'd4;
      3'd3:    n = 5'd6;
      3'd4:    n = 5'd8;
      3'd5:    n = 5'd12;
      3'd6:    n = 5'd16;
      default: n = 5'd20;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/adc_start_gate.sv
module adc_start_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic go_set,
  input  logic busy,
  output logic start_ok
);

  logic en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_d <= 1'b0;
    else        en_d <= en;
  end

  // enable must already have been high on the previous cycle
  assign start_ok = go_set && en && en_d && !busy;

endmodule

// File: rtl/adc_phase_ctrl.sv
module adc_phase_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_BITS   = 10,
  parameter int DISCH_TADS = 2,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start_ok,
  input  logic             tad_tick,
  input  logic [4:0]       acq_tads,
  output logic [CNT_W-1:0] tad_cnt,
  output logic             conv_step,
  output logic             done_evt,
  output logic             abort_evt,
  output logic             busy,
  output logic             sample_en
);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] acq_n_q;

  assign abort_evt = (phase_q != PH_IDLE) && !en;
  assign done_evt  = (phase_q == PH_DONE) && en;
  assign conv_step = (phase_q == PH_CONV) && tad_tick;
  assign busy      = (phase_q != PH_IDLE);
  assign sample_en = (phase_q == PH_IDLE) || (phase_q == PH_START) || (phase_q == PH_ACQ);
  assign tad_cnt   = cnt_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (abort_evt) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          cnt_d = '0;
          if (start_ok) phase_d = PH_START;
        end
        PH_START: begin
          cnt_d   = '0;
          phase_d = (acq_n_q == '0) ? PH_CONV : PH_ACQ;
        end
        PH_ACQ: if (tad_tick) begin
          if (cnt_q == acq_n_q - CNT_W'(1)) begin
            phase_d = PH_CONV;
            cnt_d   = '0;
          end else cnt_d = cnt_q + CNT_W'(1);
        end
        PH_CONV: if (tad_tick) begin
          if (cnt_q == CNT_W'(RES_BITS)) begin
            phase_d = PH_DISCH;
            cnt_d   = '0;
          end else cnt_d = cnt_q + CNT_W'(1);
        end
        PH_DISCH: if (tad_tick) begin
          if (cnt_q == CNT_W'(DISCH_TADS - 1)) begin
            phase_d = PH_DONE;
            cnt_d   = '0;
          end else cnt_d = cnt_q + CNT_W'(1);
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      acq_n_q <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (start_ok) acq_n_q <= CNT_W'(acq_tads);
    end
  end

  // R1
  no_busy_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);

  // R3
  start_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> busy && sample_en);

  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !busy && sample_en);

  // R8
  done_after_disch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_DONE |-> $past(tad_tick) && $past(phase_q) == PH_DISCH);

endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine #(
  parameter int RES_BITS = 10,
  parameter int CNT_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_ok,
  input  logic                conv_step,
  input  logic [CNT_W-1:0]    tad_cnt,
  input  logic                cmp_ge,
  input  logic                done_evt,
  input  logic                irq_clr,
  output logic [RES_BITS-1:0] trial,
  output logic [RES_BITS-1:0] result,
  output logic                irq_flag
);

  localparam logic [RES_BITS-1:0] TOP_ONE = {1'b1, {(RES_BITS-1){1'b0}}};

  // One step of the successive approximation: step 0 raises the MSB,
  // step k settles bit RES_BITS-k and raises the one below it.
  function automatic logic [RES_BITS-1:0] sar_next(
    input logic [RES_BITS-1:0] cur,
    input logic [CNT_W-1:0]    step,
    input logic                keep
  );
    logic [RES_BITS-1:0] v, cur_m, nxt_m;
    if (step == '0) begin
      v = TOP_ONE;
    end else begin
      cur_m = TOP_ONE >> (step - CNT_W'(1));
      nxt_m = cur_m >> 1;
      v = keep ? cur : (cur & ~cur_m);
      v = v | nxt_m;
    end
    return v;
  endfunction

  logic [RES_BITS-1:0] sar_q, res_q;
  logic                irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q <= '0;
      res_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (start_ok)       sar_q <= '0;
      else if (conv_step) sar_q <= sar_next(sar_q, tad_cnt, cmp_ge);
      if (done_evt) res_q <= sar_q;
      if (done_evt)     irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  assign trial    = sar_q;
  assign result   = res_q;
  assign irq_flag = irq_q;

  // R6
  msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_step && tad_cnt == '0 |=> trial == TOP_ONE);

  // R9
  load_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> irq_flag && result == $past(sar_q));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_evt |=> $stable(result));

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr && !done_evt |=> !irq_flag);

endmodule

// File: rtl/adc_sar_sequencer.sv
module adc_sar_sequencer
  import adc_seq_pkg::*;
#(
  parameter int RES_BITS   = 10,
  parameter int DISCH_TADS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                go_set,
  input  logic [2:0]          acq_sel,
  input  logic                tad_tick,
  input  logic                cmp_ge,
  input  logic                irq_clr,
  output logic                busy,
  output logic                sample_en,
  output logic [RES_BITS-1:0] trial,
  output logic [RES_BITS-1:0] result,
  output logic                irq_flag
);

  localparam int CNT_MAX = (RES_BITS > 20) ? ((RES_BITS > DISCH_TADS) ? RES_BITS : DISCH_TADS)
                                           : ((DISCH_TADS > 20) ? DISCH_TADS : 20);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             start_ok;
  logic [CNT_W-1:0] tad_cnt;
  logic             conv_step, done_evt, abort_evt;

  adc_start_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .go_set   (go_set),
    .busy     (busy),
    .start_ok (start_ok)
  );

  adc_phase_ctrl #(
    .RES_BITS   (RES_BITS),
    .DISCH_TADS (DISCH_TADS),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .start_ok  (start_ok),
    .tad_tick  (tad_tick),
    .acq_tads  (acq_len(acq_sel)),
    .tad_cnt   (tad_cnt),
    .conv_step (conv_step),
    .done_evt  (done_evt),
    .abort_evt (abort_evt),
    .busy      (busy),
    .sample_en (sample_en)
  );

  adc_sar_engine #(
    .RES_BITS (RES_BITS),
    .CNT_W    (CNT_W)
  ) u_sar (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ok  (start_ok),
    .conv_step (conv_step),
    .tad_cnt   (tad_cnt),
    .cmp_ge    (cmp_ge),
    .done_evt  (done_evt),
    .irq_clr   (irq_clr),
    .trial     (trial),
    .result    (result),
    .irq_flag  (irq_flag)
  );

endmodule

// File: tb/tb_adc_sar_sequencer.sv
module tb_adc_sar_sequencer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, go_set = 1'b0, tad_tick = 1'b0, irq_clr = 1'b0;
  logic [2:0] acq_sel = 3'd0;
  logic [9:0] vin = 10'd0;
  logic       cmp_ge, busy, sample_en, irq_flag;
  logic [9:0] trial, result;

  int n_chk = 0, n_bad = 0;
  bit reported = 0;

  always #10 clk = ~clk;

  assign cmp_ge = (vin >= trial);

  adc_sar_sequencer dut (
    .clk(clk), .rst_n(rst_n), .en(en), .go_set(go_set), .acq_sel(acq_sel),
    .tad_tick(tad_tick), .cmp_ge(cmp_ge), .irq_clr(irq_clr),
    .busy(busy), .sample_en(sample_en), .trial(trial), .result(result),
    .irq_flag(irq_flag)
  );

  function automatic int exp_acq(input int code);
    return (code <= 4) ? 2 * code : 4 * code - 8;
  endfunction

  function automatic logic [9:0] exp_sar(input logic [9:0] v);
    logic [9:0] t = '0;
    for (int b = 9; b >= 0; b--) begin
      t[b] = 1'b1;
      if (!(v >= t)) t[b] = 1'b0;
    end
    return t;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endtask

  task automatic clear_flag();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk(irq_flag == 1'b0, "R10 clear", irq_flag, 0);
  endtask

  task automatic do_conv(input logic [2:0] code, input logic [9:0] v, input int per,
                         input bit extra_go);
    logic [9:0] prev_res;
    int acq = 0, conv = 0, cyc = 0;
    bit first = 1, msbchk = 0, moved = 0;
    acq_sel = code; vin = v; prev_res = result;
    @(negedge clk); go_set = 1'b1; tad_tick = 1'b0;
    @(negedge clk); go_set = 1'b0;
    chk(busy == 1'b1, "R3 busy", busy, 1);
    chk(sample_en == 1'b1, "R3 sample", sample_en, 1);
    while (busy && cyc < 2000) begin
      if (msbchk) begin
        chk(trial == 10'h200, "R6 msb trial", trial, 10'h200);
        msbchk = 0;
      end
      if (result != prev_res) moved = 1;
      tad_tick = ((cyc % per) == 0);
      go_set = extra_go && (cyc == 5);
      if (tad_tick && !first) begin
        if (sample_en) acq++;
        else begin
          if (conv == 0) msbchk = 1;
          conv++;
        end
      end
      first = 0; cyc++;
      @(negedge clk);
    end
    tad_tick = 1'b0; go_set = 1'b0;
    chk(acq == exp_acq(code), "R4 acq ticks", acq, exp_acq(code));
    chk(conv == 13, "R8 conv+disch ticks", conv, 13);
    chk(result == exp_sar(v), "R7 result", result, exp_sar(v));
    chk(irq_flag == 1'b1, "R9 flag", irq_flag, 1);
    chk(sample_en == 1'b1, "R5 sample back", sample_en, 1);
    chk(moved == 0, "R9 early load", moved, 0);
  endtask

  initial begin
    int cyc_w = 0;
    forever begin
      @(posedge clk);
      cyc_w++;
      if (cyc_w > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc_w, 150000);
        summary();
        $finish;
      end
    end
  end

  initial begin
    logic [9:0] keep;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    chk(sample_en == 1'b1, "R5 reset sample", sample_en, 1);
    chk(irq_flag == 1'b0, "R10 reset flag", irq_flag, 0);
    chk(result == 10'd0, "R9 reset result", result, 0);

    // R1: disabled start
    @(negedge clk); go_set = 1'b1;
    @(negedge clk); go_set = 1'b0;
    chk(busy == 1'b0, "R1 disabled go", busy, 0);

    // R2: start in the same cycle enable turns on
    @(negedge clk); en = 1'b1; go_set = 1'b1;
    @(negedge clk); go_set = 1'b0;
    chk(busy == 1'b0, "R2 same-cycle go", busy, 0);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && irq_flag == 1'b0, "R2 still idle", busy, 0);

    // directed corners
    do_conv(3'd0, 10'd0, 2, 0);
    clear_flag();
    do_conv(3'd2, 10'd1023, 3, 0);
    repeat (4) @(negedge clk);
    chk(irq_flag == 1'b1, "R10 sticky", irq_flag, 1);
    clear_flag();
    do_conv(3'd7, 10'h155, 2, 1);   // R12 second go while busy
    clear_flag();

    // R11: abort mid-conversion
    keep = result;
    acq_sel = 3'd0; vin = 10'd300;
    @(negedge clk); go_set = 1'b1;
    @(negedge clk); go_set = 1'b0;
    for (int i = 0; i < 12; i++) begin
      tad_tick = (i % 2) == 0;
      @(negedge clk);
    end
    tad_tick = 1'b0; en = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R11 abort busy", busy, 0);
    chk(sample_en == 1'b1, "R11 abort sample", sample_en, 1);
    repeat (3) @(negedge clk);
    chk(irq_flag == 1'b0, "R11 abort flag", irq_flag, 0);
    chk(result == keep, "R11 abort result", result, keep);
    en = 1'b1;
    @(negedge clk);

    // random conversions
    for (int k = 0; k < 16; k++) begin
      do_conv(3'($urandom % 8), 10'($urandom % 1024), 2 + int'($urandom % 3), ($urandom % 4) == 0);
      clear_flag();
    end

    summary();
    $finish;
  end

endmodule